// File: doc/BRIEF.md
# Atomic 16-Bit Register Access Bridge for an 8-Bit Bus

This block sits between an 8-bit register bus and the four 16-bit registers of a timer: the running count, two compare values and the capture value. Each 16-bit register appears as two byte addresses. A single holding byte, shared by all four registers, makes every 16-bit transfer appear atomic even though the bus moves only one byte per cycle.

To write, software first writes the upper byte, which is only parked in the holding byte. It then writes the lower byte, and the bridge presents the full word to the timer in that same cycle as a one-cycle write strobe. To read, software first reads the lower byte. The bridge returns the live lower byte and, at the same clock edge, captures the live upper byte of the same register into the holding byte. A later read of the upper byte returns that captured value, so the two halves always come from the same instant. Because there is only one holding byte, interleaving accesses to different registers mixes their halves. This is allowed, and the result is whatever the holding byte contains at that moment.

Top module: `tmr16_bridge`

## Requirements
- R1: After reset the holding byte is 0x00 and no write strobe is active. A read of any upper-byte address therefore returns 0x00.
- R2: The register window begins at BASE_ADDR (default 0x84). Within it, odd offsets are upper bytes and even offsets are lower bytes. Offset bits [2:1] select the register: 0 count, 1 compare A, 2 compare B, 3 capture. A write to an upper-byte address only loads the holding byte and raises no write strobe.
- R3: A write to a lower-byte address raises exactly one bit of regWrStrobe (bit index = register select) for that single cycle. At the same time regWrWord carries {holding byte, written byte}.
- R4: A read of a lower-byte address returns the live lower byte of the selected register in the same cycle. At the clock edge it loads the live upper byte into the holding byte. When no read is requested, busRdData is 0x00.
- R5: A read of an upper-byte address returns the holding byte, not the live upper byte.
- R6: The holding byte is shared by all registers. An upper-byte write to one register followed by a lower-byte write to another commits the first register's upper byte into the second.
- R7: Addresses outside the window return 0x00, raise no strobe and leave the holding byte unchanged.
- R8: When busWr and busRd are both asserted, only the write takes effect. busRdData is 0x00, and the holding byte is not loaded from the live value.
- R9: A lower-byte write leaves the holding byte unchanged, so one upper-byte write can serve several lower-byte commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address |
| busWrData | input | 8 | Byte write data |
| busWr | input | 1 | Write request |
| busRd | input | 1 | Read request |
| cntLive | input | 16 | Live count value |
| cmpALive | input | 16 | Live compare A value |
| cmpBLive | input | 16 | Live compare B value |
| capLive | input | 16 | Live capture value |
| busRdData | output | 8 | Byte read data (combinational) |
| regWrStrobe | output | 4 | One-hot commit strobe per register |
| regWrWord | output | 16 | Word committed with the strobe |

## Verification
The hardest case to reach is proving that a read of the upper byte returns the holding byte rather than the live value. That difference only shows when the live word changes between the two halves of the read. The bench therefore changes the live count between the lower-byte and upper-byte reads, and expects the old upper byte. The bench also proves that out-of-range and simultaneous read-and-write accesses leave the holding byte alone, which is only visible later: a following commit or upper-byte read must still show the earlier value.

// File: rtl/tmr16_bridge_pkg.sv
package tmr16_bridge_pkg;
  localparam int NREG  = 4;
  localparam int SEL_W = $clog2(NREG);

  typedef struct packed {
    logic              holdFromBus;  // upper-byte write
    logic              commit;       // lower-byte write
    logic              holdFromLive; // lower-byte read
    logic              rdLow;
    logic              rdHigh;
    logic [SEL_W-1:0]  sel;
  } bridgeStrb_t;
endpackage

// File: rtl/tmr16_bridge_ctrl.sv
module tmr16_bridge_ctrl
  import tmr16_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h84
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output bridgeStrb_t       strb
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * NREG);

  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic              rdOnly;

  assign offset = busAddr - BASE_ADDR;
  assign hit    = (busAddr >= BASE_ADDR) && (offset < SPAN);
  assign rdOnly = busRd && !busWr;

  always_comb begin
    strb              = '0;
    strb.sel          = offset[SEL_W:1];
    strb.holdFromBus  = hit && busWr && offset[0];
    strb.commit       = hit && busWr && !offset[0];
    strb.holdFromLive = hit && rdOnly && !offset[0];
    strb.rdLow        = hit && rdOnly && !offset[0];
    strb.rdHigh       = hit && rdOnly && offset[0];
  end
endmodule

// File: rtl/tmr16_bridge_dp.sv
module tmr16_bridge_dp
  import tmr16_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bridgeStrb_t                    strb,
  input  logic [DATA_W-1:0]              busWrData,
  input  logic [NREG-1:0][2*DATA_W-1:0]  liveWords,
  output logic [DATA_W-1:0]              busRdData,
  output logic [NREG-1:0]                regWrStrobe,
  output logic [2*DATA_W-1:0]            regWrWord
);
  logic [DATA_W-1:0]   holdByte;
  logic [2*DATA_W-1:0] liveSel;

  assign liveSel = liveWords[strb.sel];

  always_ff @(posedge clk) begin
    if (!rstN)                  holdByte <= '0;
    else if (strb.holdFromBus)  holdByte <= busWrData;
    else if (strb.holdFromLive) holdByte <= liveSel[2*DATA_W-1:DATA_W];
  end

  always_comb begin
    busRdData = '0;
    if (strb.rdLow)       busRdData = liveSel[DATA_W-1:0];
    else if (strb.rdHigh) busRdData = holdByte;
  end

  assign regWrWord = {holdByte, busWrData};

  for (genvar i = 0; i < NREG; i++) begin : g_strobe
    assign regWrStrobe[i] = strb.commit && (strb.sel == SEL_W'(i));
  end
endmodule

// File: rtl/tmr16_bridge.sv
module tmr16_bridge
  import tmr16_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h84
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [2*DATA_W-1:0] cntLive,
  input  logic [2*DATA_W-1:0] cmpALive,
  input  logic [2*DATA_W-1:0] cmpBLive,
  input  logic [2*DATA_W-1:0] capLive,
  output logic [DATA_W-1:0]   busRdData,
  output logic [NREG-1:0]     regWrStrobe,
  output logic [2*DATA_W-1:0] regWrWord
);
  bridgeStrb_t                   strb;
  logic [NREG-1:0][2*DATA_W-1:0] liveWords;

  assign liveWords = {capLive, cmpBLive, cmpALive, cntLive};

  tmr16_bridge_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uCtrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  tmr16_bridge_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .liveWords(liveWords), .busRdData(busRdData),
    .regWrStrobe(regWrStrobe), .regWrWord(regWrWord)
  );
endmodule

// File: rtl/tmr16_bridge_chk.sv
module tmr16_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h84
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWrData,
  input logic                busWr,
  input logic                busRd,
  input logic [2*DATA_W-1:0] cntLive,
  input logic [2*DATA_W-1:0] cmpALive,
  input logic [2*DATA_W-1:0] cmpBLive,
  input logic [2*DATA_W-1:0] capLive,
  input logic [DATA_W-1:0]   busRdData,
  input logic [3:0]          regWrStrobe,
  input logic [2*DATA_W-1:0] regWrWord
);
  logic [ADDR_W-1:0]   off;
  logic                inRange;
  logic                isHigh;
  logic [1:0]          idx;
  logic [2*DATA_W-1:0] liveSel;

  assign off     = busAddr - BASE_ADDR;
  assign inRange = (busAddr >= BASE_ADDR) && (off < ADDR_W'(8));
  assign isHigh  = off[0];
  assign idx     = off[2:1];

  always_comb begin
    case (idx)
      2'd0:    liveSel = cntLive;
      2'd1:    liveSel = cmpALive;
      2'd2:    liveSel = cmpBLive;
      default: liveSel = capLive;
    endcase
  end

  // R7
  oob_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> (busRdData == '0 && regWrStrobe == '0));

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regWrStrobe));

  // R3
  commit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && inRange && !isHigh) |-> (regWrStrobe[idx] && regWrWord[DATA_W-1:0] == busWrData));

  // R2
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && inRange && !isHigh) |-> (regWrStrobe == '0));

  // R9
  held_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWr && inRange && isHigh) && busWr && inRange && !isHigh)
      |-> (regWrWord[2*DATA_W-1:DATA_W] == $past(busWrData)));

  // R4
  low_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && inRange && !isHigh) |-> (busRdData == liveSel[DATA_W-1:0]));

  // R5
  high_read_snap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRd && !busWr && inRange && !isHigh) && busRd && !busWr && inRange && isHigh)
      |-> (busRdData == $past(liveSel[2*DATA_W-1:DATA_W])));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> (busRdData == '0));
endmodule

bind tmr16_bridge tmr16_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) uChk (.*);

// File: tb/sim_tmr16_bridge.sv
module sim_tmr16_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] cntLive = '0;
  logic [15:0] cmpALive = '0;
  logic [15:0] cmpBLive = '0;
  logic [15:0] capLive = '0;
  logic [7:0]  busRdData;
  logic [3:0]  regWrStrobe;
  logic [15:0] regWrWord;

  int checks = 0;
  int errors = 0;
  logic [7:0]  sRd;
  logic [3:0]  sStb;
  logic [15:0] sWord;

  always #2.5 clk = ~clk;

  tmr16_bridge u0 (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, sample before posedge
  task automatic busCycle(logic wr, logic rd, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busWrData = d;
    #1;
    sRd = busRdData; sStb = regWrStrobe; sWord = regWrWord;
    @(posedge clk);
    #0.5;
    busWr = 1'b0; busRd = 1'b0; busAddr = 8'h00;
  endtask

  task automatic tReset();
    busCycle(0, 0, 8'h00, 8'h00);
    check("R1 idle strobe", 16'(sStb), 16'h0);
    busCycle(0, 1, 8'h85, 8'h00);
    check("R1 hold after reset", 16'(sRd), 16'h00);
  endtask

  task automatic tWrite16();
    busCycle(1, 0, 8'h87, 8'h25);
    check("R2 upper write no strobe", 16'(sStb), 16'h0);
    busCycle(1, 0, 8'h86, 8'h64);
    check("R3 strobe cmpA", 16'(sStb), 16'b0010);
    check("R3 word", sWord, 16'h2564);
  endtask

  task automatic tRead16();
    cntLive = 16'h1234;
    busCycle(0, 1, 8'h84, 8'h00);
    check("R4 low live", 16'(sRd), 16'h34);
    cntLive = 16'hABCD;
    busCycle(0, 1, 8'h85, 8'h00);
    check("R5 upper from hold", 16'(sRd), 16'h12);
    busCycle(0, 0, 8'h84, 8'h00);
    check("R4 idle read data", 16'(sRd), 16'h00);
  endtask

  task automatic tShared();
    busCycle(1, 0, 8'h89, 8'h77);
    busCycle(1, 0, 8'h8A, 8'h11);
    check("R6 strobe capture", 16'(sStb), 16'b1000);
    check("R6 mixed word", sWord, 16'h7711);
  endtask

  task automatic tReuse();
    busCycle(1, 0, 8'h84, 8'h22);
    check("R9 strobe count", 16'(sStb), 16'b0001);
    check("R9 reused upper", sWord, 16'h7722);
  endtask

  task automatic tOutOfRange();
    busCycle(1, 0, 8'h83, 8'h99);
    check("R7 low-side strobe", 16'(sStb), 16'h0);
    busCycle(1, 1, 8'h8D, 8'h98);
    check("R7 high-side strobe", 16'(sStb), 16'h0);
    busCycle(0, 1, 8'h8C, 8'h00);
    check("R7 read zero", 16'(sRd), 16'h00);
    busCycle(1, 0, 8'h86, 8'h01);
    check("R7 hold untouched", sWord, 16'h7701);
  endtask

  task automatic tBoth();
    capLive = 16'hC3C3;
    busCycle(1, 1, 8'h8B, 8'h5A);
    check("R8 read data zero", 16'(sRd), 16'h00);
    cntLive = 16'hEE44;
    busCycle(1, 1, 8'h84, 8'h06);
    check("R8 commit", sWord, 16'h5A06);
    check("R8 strobe", 16'(sStb), 16'b0001);
    busCycle(0, 1, 8'h8B, 8'h00);
    check("R8 hold from write", 16'(sRd), 16'h5A);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rstN = 1'b1;
    tReset();
    tWrite16();
    tRead16();
    tShared();
    tReuse();
    tOutOfRange();
    tBoth();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule